// File: doc/BRIEF.md
# Chained DMA Descriptor Engine

This block is a small DMA engine that serves several peripheral request lines. An internal single-port RAM holds a table of vector slots, one slot per request line, and each slot holds the RAM address of a six-word transfer descriptor. When a line is served, the engine reads its slot, fetches the descriptor, and copies words from the source pointer to the destination pointer. It either copies one word per request or copies the whole remaining count in one go. It then writes the updated count and pointers back into the descriptor.

When the count reaches zero the engine finishes the job. If linking is enabled, it overwrites the requesting line's own vector slot with the descriptor's link word, so the next request from that line runs a different descriptor. If notification is enabled, it raises an end-of-transfer interrupt that carries the handler address stored in the descriptor. Software, or the bench, loads the table, descriptors and buffers through a valid/ready host port. This port is only ready while the engine is idle. A master must hold `host_valid_i` and its address, data and write-enable stable until it sees `host_ready_o` high at a clock edge. A read returns its data one cycle after acceptance, flagged by `host_rvalid_o`.

Top module: `cdma_top`

## Requirements
- R1: After reset, `host_ready_o` is 1 and `req_ack_o`, `irq_o` and `host_rvalid_o` are 0.
- R2: An idle engine that sees any request line high, with no host access pending, serves the lowest-numbered active line. It pulses that line's bit of `req_ack_o` for exactly one cycle, and no other bit.
- R3: The slot for line i sits at word address VEC_BASE+i (VEC_BASE is 0 by default). The descriptor words at offsets +0..+5 are: mode, count, source pointer, destination pointer, link word and handler address. Mode bit 0 is NOTIFY, bit 1 is LINK and bit 2 is BURST.
- R4: With BURST set, one request copies all `count` words in ascending address order from source to destination. No word past the last one is written, and the count word in RAM ends at 0.
- R5: With BURST clear, one request copies one word. The descriptor's count, source and destination words are then written back as count-1, source+1 and destination+1.
- R6: When the count reaches 0 with LINK set, the link word is written into the served line's slot. The next request from that line fetches its descriptor from that address.
- R7: When the count reaches 0 with NOTIFY set, `irq_o` pulses for one cycle. During that cycle `irq_addr_o` is the handler word and `irq_src_o` is the served line. No interrupt is raised while the count is still above 0.
- R8: With LINK and NOTIFY both set, the slot rewrite has already taken effect in the cycle in which `irq_o` is high. A host read accepted in that cycle returns the link word.
- R9: A descriptor whose count is already 0 moves no data, but it still performs the LINK and NOTIFY actions.
- R10: `host_ready_o` is low from request acceptance until the engine is idle again. A host read returns its data, with `host_rvalid_o` high, in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NREQ | Peripheral request lines, held until acknowledged |
| req_ack_o | output | NREQ | One-cycle acknowledge of the line being served |
| host_valid_i | input | 1 | Host access request |
| host_ready_o | output | 1 | Host access accepted at this edge (engine idle) |
| host_we_i | input | 1 | Host access is a write |
| host_addr_i | input | AW | Host word address |
| host_wdata_i | input | DW | Host write data |
| host_rvalid_o | output | 1 | Host read data valid |
| host_rdata_o | output | DW | Host read data |
| irq_o | output | 1 | End-of-transfer interrupt pulse |
| irq_addr_o | output | DW | Handler address presented with the interrupt |
| irq_src_o | output | IW | Request line that completed |

## Verification
Two completion actions can fall into the same step: the slot rewrite and the interrupt. This happens when a descriptor has both LINK and NOTIFY set, including the case where its count is already zero. The bench watches every cycle of a service. In the very cycle it sees `irq_o`, it issues a host read of the served slot, and it requires the link word back. A later request on the same line must then run the linked descriptor, which is judged by that descriptor's distinct handler address and destination data.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int DESC_WORDS = 6;
  localparam int F_MODE = 0;
  localparam int F_CNT  = 1;
  localparam int F_SRC  = 2;
  localparam int F_DST  = 3;
  localparam int F_LNK  = 4;
  localparam int F_HND  = 5;
  localparam int B_NOTIFY = 0;
  localparam int B_LINK   = 1;
  localparam int B_BURST  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_VEC, ST_FETCH, ST_DEC, ST_RD, ST_WR, ST_WB, ST_DONE
  } cdma_st_t;
endpackage

// File: rtl/cdma_ram.sv
module cdma_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/cdma_prio.sv
module cdma_prio #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);
  always_comb begin
    any   = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any      = 1'b1;
        idx      = IW'(i);
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
  import cdma_pkg::*;
#(
  parameter int NREQ     = 4,
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int VEC_BASE = 0,
  parameter int IW       = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_any,
  input  logic [IW-1:0]   req_idx,
  input  logic [NREQ-1:0] req_grant,
  input  logic            host_valid,
  output logic            idle,
  output logic            m_en,
  output logic            m_we,
  output logic [AW-1:0]   m_addr,
  output logic [DW-1:0]   m_wdata,
  input  logic [DW-1:0]   m_rdata,
  output logic [NREQ-1:0] ack,
  output logic            irq,
  output logic [DW-1:0]   irq_addr,
  output logic [IW-1:0]   irq_src
);
  localparam int KW = $clog2(DESC_WORDS + 1);

  cdma_st_t        st;
  logic [IW-1:0]   sel;
  logic [KW-1:0]   k;
  logic [AW-1:0]   dbase;
  logic [AW-1:0]   dptr;
  logic [AW-1:0]   slot_addr;
  logic [DW-1:0]   fld [DESC_WORDS];

  assign idle      = (st == ST_IDLE);
  assign slot_addr = AW'(VEC_BASE) + AW'(sel);
  assign dptr      = (k == '0) ? AW'(m_rdata) : dbase;

  always_comb begin
    m_en    = 1'b0;
    m_we    = 1'b0;
    m_addr  = '0;
    m_wdata = '0;
    unique case (st)
      ST_VEC: begin
        m_en   = 1'b1;
        m_addr = slot_addr;
      end
      ST_FETCH: if (int'(k) < DESC_WORDS) begin
        m_en   = 1'b1;
        m_addr = dptr + AW'(k);
      end
      ST_RD: begin
        m_en   = 1'b1;
        m_addr = AW'(fld[F_SRC]);
      end
      ST_WR: begin
        m_en    = 1'b1;
        m_we    = 1'b1;
        m_addr  = AW'(fld[F_DST]);
        m_wdata = m_rdata;
      end
      ST_WB: begin
        m_en   = 1'b1;
        m_we   = 1'b1;
        m_addr = dbase + AW'(F_CNT) + AW'(k);
        case (int'(k))
          0:       m_wdata = fld[F_CNT];
          1:       m_wdata = fld[F_SRC];
          default: m_wdata = fld[F_DST];
        endcase
      end
      ST_DONE: if (fld[F_MODE][B_LINK]) begin
        m_en    = 1'b1;
        m_we    = 1'b1;
        m_addr  = slot_addr;
        m_wdata = fld[F_LNK];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sel      <= '0;
      k        <= '0;
      dbase    <= '0;
      ack      <= '0;
      irq      <= 1'b0;
      irq_addr <= '0;
      irq_src  <= '0;
      for (int j = 0; j < DESC_WORDS; j++) fld[j] <= '0;
    end else begin
      ack <= '0;
      irq <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_any && !host_valid) begin
          sel <= req_idx;
          ack <= req_grant;
          st  <= ST_VEC;
        end
        ST_VEC: begin
          k  <= '0;
          st <= ST_FETCH;
        end
        ST_FETCH: begin
          if (k == '0) dbase <= AW'(m_rdata);
          for (int j = 0; j < DESC_WORDS; j++)
            if (int'(k) == j + 1) fld[j] <= m_rdata;
          k <= k + 1'b1;
          if (int'(k) == DESC_WORDS) st <= ST_DEC;
        end
        ST_DEC: st <= (fld[F_CNT] == '0) ? ST_DONE : ST_RD;
        ST_RD:  st <= ST_WR;
        ST_WR: begin
          fld[F_SRC] <= fld[F_SRC] + 1'b1;
          fld[F_DST] <= fld[F_DST] + 1'b1;
          fld[F_CNT] <= fld[F_CNT] - 1'b1;
          if (fld[F_MODE][B_BURST] && fld[F_CNT] != DW'(1)) begin
            st <= ST_RD;
          end else begin
            k  <= '0;
            st <= ST_WB;
          end
        end
        ST_WB: begin
          k <= k + 1'b1;
          if (int'(k) == 2) st <= (fld[F_CNT] == '0) ? ST_DONE : ST_IDLE;
        end
        ST_DONE: begin
          irq      <= fld[F_MODE][B_NOTIFY];
          irq_addr <= fld[F_HND];
          irq_src  <= sel;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cdma_top.sv
module cdma_top #(
  parameter int NREQ     = 4,
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int VEC_BASE = 0,
  parameter int IW       = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_i,
  output logic [NREQ-1:0] req_ack_o,
  input  logic            host_valid_i,
  output logic            host_ready_o,
  input  logic            host_we_i,
  input  logic [AW-1:0]   host_addr_i,
  input  logic [DW-1:0]   host_wdata_i,
  output logic            host_rvalid_o,
  output logic [DW-1:0]   host_rdata_o,
  output logic            irq_o,
  output logic [DW-1:0]   irq_addr_o,
  output logic [IW-1:0]   irq_src_o
);
  logic            pr_any;
  logic [IW-1:0]   pr_idx;
  logic [NREQ-1:0] pr_grant;
  logic            eng_idle;
  logic            e_en, e_we;
  logic [AW-1:0]   e_addr;
  logic [DW-1:0]   e_wdata;
  logic            r_en, r_we;
  logic [AW-1:0]   r_addr;
  logic [DW-1:0]   r_wdata, r_rdata;
  logic            host_go;

  cdma_prio #(.N(NREQ), .IW(IW)) u_prio (
    .req(req_i), .any(pr_any), .idx(pr_idx), .grant(pr_grant)
  );

  cdma_seq #(.NREQ(NREQ), .AW(AW), .DW(DW), .VEC_BASE(VEC_BASE), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_any(pr_any), .req_idx(pr_idx), .req_grant(pr_grant),
    .host_valid(host_valid_i), .idle(eng_idle),
    .m_en(e_en), .m_we(e_we), .m_addr(e_addr), .m_wdata(e_wdata), .m_rdata(r_rdata),
    .ack(req_ack_o), .irq(irq_o), .irq_addr(irq_addr_o), .irq_src(irq_src_o)
  );

  assign host_ready_o = eng_idle;
  assign host_go      = host_valid_i & eng_idle;
  assign r_en         = host_go | e_en;
  assign r_we         = host_go ? host_we_i    : e_we;
  assign r_addr       = host_go ? host_addr_i  : e_addr;
  assign r_wdata      = host_go ? host_wdata_i : e_wdata;
  assign host_rdata_o = r_rdata;

  cdma_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .en(r_en), .we(r_we), .addr(r_addr), .wdata(r_wdata), .rdata(r_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rvalid_o <= 1'b0;
    else        host_rvalid_o <= host_go & ~host_we_i;
  end
endmodule

// File: rtl/cdma_sva.sv
module cdma_sva #(
  parameter int NREQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_i,
  input logic [NREQ-1:0] req_ack_o,
  input logic            irq_o,
  input logic            host_ready_o,
  input logic            host_valid_i,
  input logic            host_we_i,
  input logic            host_rvalid_o
);
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ack_o)); // R2
  AST_ACK_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack_o != '0) |-> ((req_ack_o & ~$past(req_i)) == '0)); // R2
  AST_ACK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack_o != '0) |-> (((req_ack_o - 1'b1) & $past(req_i)) == '0)); // R2
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack_o != '0) |=> (req_ack_o == '0)); // R2
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R7
  AST_IRQ_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> host_ready_o); // R8
  AST_BUSY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack_o != '0) |-> !host_ready_o); // R10
  AST_RVALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid_i && host_ready_o && !host_we_i) |=> host_rvalid_o); // R10
endmodule

bind cdma_top cdma_sva #(.NREQ(NREQ)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_ack_o(req_ack_o),
  .irq_o(irq_o), .host_ready_o(host_ready_o), .host_valid_i(host_valid_i),
  .host_we_i(host_we_i), .host_rvalid_o(host_rvalid_o)
);

// File: tb/cdma_top_tb_top.sv
module cdma_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int LIMIT = 20000;
  localparam int NCASE = 5;
  localparam logic [7:0] LINK_DESC = 8'h40;
  // {line[15:12], mode[11:8], count[7:0]}; mode bit0 NOTIFY, bit1 LINK, bit2 BURST
  localparam logic [15:0] TBL [NCASE] = '{16'h0703, 16'h1102, 16'h2404, 16'h3201, 16'h1700};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREQ-1:0] req = '0;
  logic [NREQ-1:0] ack;
  logic hv = 1'b0, hwe = 1'b0;
  logic [AW-1:0] ha = '0;
  logic [DW-1:0] hwd = '0;
  logic hrdy, hrv, irq;
  logic [DW-1:0] hrd, iaddr;
  logic [IW-1:0] isrc;
  int total = 0, bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cdma_top #(.NREQ(NREQ), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_ack_o(ack),
    .host_valid_i(hv), .host_ready_o(hrdy), .host_we_i(hwe), .host_addr_i(ha),
    .host_wdata_i(hwd), .host_rvalid_o(hrv), .host_rdata_o(hrd),
    .irq_o(irq), .irq_addr_o(iaddr), .irq_src_o(isrc)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic hwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (!hrdy) @(negedge clk);
    hv = 1'b1; hwe = 1'b1; ha = a; hwd = d;
    @(posedge clk);
    @(negedge clk);
    hv = 1'b0; hwe = 1'b0;
  endtask

  task automatic hread(input logic [AW-1:0] a, output logic [DW-1:0] d);
    while (!hrdy) @(negedge clk);
    hv = 1'b1; hwe = 1'b0; ha = a;
    @(posedge clk);
    @(negedge clk);
    hv = 1'b0;
    chk("R10 rvalid", 32'(hrv), 32'd1);
    d = hrd;
  endtask

  task automatic serve(input int line, output logic got, output logic [DW-1:0] ia,
                       output logic [IW-1:0] is);
    got = 1'b0; ia = '0; is = '0;
    req[line] = 1'b1;
    @(negedge clk);
    while (!ack[line]) @(negedge clk);
    req[line] = 1'b0;
    do begin
      @(negedge clk);
      if (irq) begin got = 1'b1; ia = iaddr; is = isrc; end
    end while (!hrdy);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog actual=%0d expected<%0d", LIMIT, LIMIT);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    logic got;
    logic [DW-1:0] ia;
    logic [IW-1:0] is;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(hrdy), 32'd1);
    chk("R1 ack", 32'(ack), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 rvalid", 32'(hrv), 32'd0);

    for (int e = 0; e < NCASE; e++) begin
      int line, cnt, nreq;
      logic [3:0] mode;
      logic [AW-1:0] d, s, t;
      line = int'(TBL[e][15:12]); mode = TBL[e][11:8]; cnt = int'(TBL[e][7:0]);
      d = AW'(8'h10 + 8 * e); s = AW'(8'h80 + 8 * e); t = AW'(8'hC0 + 8 * e);
      // R3 slot and descriptor layout
      hwrite(AW'(line), DW'(d));
      hwrite(d + 0, DW'(mode));
      hwrite(d + 1, DW'(cnt));
      hwrite(d + 2, DW'(s));
      hwrite(d + 3, DW'(t));
      hwrite(d + 4, DW'(LINK_DESC));
      hwrite(d + 5, DW'(16'h1000 + e));
      for (int j = 0; j <= cnt; j++) begin
        hwrite(s + AW'(j), DW'(16'hA000 + e * 16 + j));
        hwrite(t + AW'(j), '0);
      end
      nreq = (mode[2] || cnt == 0) ? 1 : cnt;
      for (int r = 0; r < nreq; r++) begin
        logic last;
        last = (r == nreq - 1);
        serve(line, got, ia, is);
        // R8: slot read accepted in the interrupt cycle
        hread(AW'(line), rd);
        chk((last && mode[1]) ? "R6 R8 slot" : "R6 slot kept", 32'(rd),
            (last && mode[1]) ? 32'(LINK_DESC) : 32'(d));
        chk("R7 irq", 32'(got), 32'(last && mode[0]));
        if (got) begin
          chk("R7 irq addr", 32'(ia), 32'h1000 + 32'(e));
          chk("R7 irq src", 32'(is), 32'(line));
        end
        if (!last) begin
          hread(d + 1, rd); chk("R5 count wb", 32'(rd), 32'(cnt - 1 - r));
          hread(d + 2, rd); chk("R5 src wb", 32'(rd), 32'(s) + 32'(r + 1));
          hread(d + 3, rd); chk("R5 dst wb", 32'(rd), 32'(t) + 32'(r + 1));
        end
      end
      for (int j = 0; j < cnt; j++) begin
        hread(t + AW'(j), rd);
        chk(mode[2] ? "R4 burst data" : "R5 single data", 32'(rd), 32'h0000A000 + 32'(e * 16 + j));
      end
      hread(t + AW'(cnt), rd);
      chk(cnt == 0 ? "R9 no data" : "R4 no overrun", 32'(rd), 32'd0);
      hread(d + 1, rd);
      chk("R4 count zero", 32'(rd), 32'd0);
    end

    // R6: line 0 slot now points at LINK_DESC; the next request runs it
    hwrite(LINK_DESC + 0, 16'h0005);
    hwrite(LINK_DESC + 1, 16'h0001);
    hwrite(LINK_DESC + 2, 16'h00F8);
    hwrite(LINK_DESC + 3, 16'h00F0);
    hwrite(LINK_DESC + 4, 16'h0000);
    hwrite(LINK_DESC + 5, 16'h2222);
    hwrite(8'hF8, 16'hBEEF);
    hwrite(8'hF0, 16'h0000);
    serve(0, got, ia, is);
    chk("R6 linked irq", 32'(got), 32'd1);
    chk("R6 linked handler", 32'(ia), 32'h2222);
    hread(8'hF0, rd);
    chk("R6 linked data", 32'(rd), 32'hBEEF);

    // R2 priority: lines 1 and 2 together, zero-count descriptors without flags
    hwrite(8'h48, 16'h0000);
    hwrite(8'h49, 16'h0000);
    hwrite(8'h01, 16'h0048);
    hwrite(8'h02, 16'h0048);
    req = 4'b0110;
    @(negedge clk);
    while (ack == '0) @(negedge clk);
    chk("R2 lowest wins", 32'(ack), 32'b0010);
    chk("R10 busy", 32'(hrdy), 32'd0);
    req[1] = 1'b0;
    @(negedge clk);
    chk("R2 ack pulse", 32'(ack), 32'd0);
    while (ack == '0) @(negedge clk);
    chk("R2 second line", 32'(ack), 32'b0100);
    req[2] = 1'b0;
    while (!hrdy) @(negedge clk);
    chk("R9 no irq without notify", 32'(irq), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule